// File: doc/BRIEF.md
# Width-Aware Register Transfer Unit

This block holds a 16-bit accumulator, made of a low byte and a high byte, and two 16-bit index registers, X and Y. Each clock cycle it can perform one register-to-register move or a byte exchange inside the accumulator. The amount of data a move carries depends on two width controls: one for the accumulator and one for the index pair. When the two sides differ in width, the register being written sets the width of the move. Moves from an 8-bit index into a 16-bit accumulator fill the upper accumulator byte with zero. Moves into an 8-bit accumulator leave the upper byte untouched.

Each register also has a direct load port, which is how surrounding logic puts values in. The index pair follows its width control: while it is narrow, the upper index bytes read as zero, and narrowing the pair wipes the stored upper bytes. All state is registered. A move or load becomes visible after the next rising clock edge.

Top module: `rtm_xfer_unit`

## Requirements
- R1: Asserting the active-low reset clears the accumulator, X and Y to zero, and they read zero on the outputs.
- R2: A load writes its register at the next edge and takes priority over any move that targets the same register in that cycle. With the accumulator at 8 bits, an accumulator load writes only the low byte and keeps the high byte. With the index pair at 8 bits, an index load writes the low byte and zeroes the high byte.
- R3: The move opcode is 3 bits: 0 no move, 1 accumulator byte swap, 2 accumulator to X, 3 accumulator to Y, 4 X to accumulator, 5 Y to accumulator, 6 X to Y, 7 Y to X. A width control of 1 means 8 bits and 0 means 16 bits. Opcode 0 holds all registers.
- R4: The byte swap exchanges the low and high accumulator bytes. It does this whether the accumulator is 8 or 16 bits wide.
- R5: Accumulator to X (or Y) with a 16-bit index pair copies the whole 16-bit accumulator, high:low, for either accumulator width.
- R6: Accumulator to X (or Y) with an 8-bit index pair copies only the low accumulator byte, and the destination's high byte becomes zero.
- R7: X (or Y) to accumulator with an 8-bit accumulator copies the low index byte into the low accumulator byte and keeps the high accumulator byte.
- R8: X (or Y) to accumulator with a 16-bit accumulator copies the full index value. When the index pair is 8 bits, this writes zero into the high accumulator byte.
- R9: X to Y and Y to X copy the full index value, or only its low byte while the index pair is narrow.
- R10: While the index width control is 1, the high bytes of x_o and y_o read zero in the same cycle, before any clock edge.
- R11: Any cycle with the index width control at 1 clears the stored high bytes of X and Y at the edge. Returning to 16 bits afterwards shows zero high bytes until they are written again.
- R12: Results are registered: a move presented on the inputs does not change any output before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Move opcode (see R3) |
| acc_narrow_i | input | 1 | 1 = accumulator 8 bits, 0 = 16 bits |
| idx_narrow_i | input | 1 | 1 = index pair 8 bits, 0 = 16 bits |
| ld_acc_i | input | 1 | Load accumulator from ld_acc_val_i |
| ld_acc_val_i | input | 16 | Accumulator load value |
| ld_x_i | input | 1 | Load X from ld_x_val_i |
| ld_x_val_i | input | 16 | X load value |
| ld_y_i | input | 1 | Load Y from ld_y_val_i |
| ld_y_val_i | input | 16 | Y load value |
| acc_o | output | 16 | Accumulator, high byte : low byte |
| x_o | output | 16 | X register as seen at the current index width |
| y_o | output | 16 | Y register as seen at the current index width |

## Verification
The hardest state to reach from the ports is a stored upper index byte that was wiped by a period of narrow index width. While the pair is narrow, the output mask hides the upper byte whether or not it was cleared. The stimulus therefore first fills X and Y with non-zero upper bytes at 16 bits, spends one cycle at 8 bits, and then returns to 16 bits with no write. Only then does the cleared upper byte show on x_o and y_o. A second hard case is a load and a move aimed at the same register in one cycle. It is driven on purpose to show that the load wins.

// File: rtl/rtm_pkg.sv
`timescale 1ns/1ps
package rtm_pkg;
   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_SWAP = 3'd1,
      OP_A2X  = 3'd2,
      OP_A2Y  = 3'd3,
      OP_X2A  = 3'd4,
      OP_Y2A  = 3'd5,
      OP_X2Y  = 3'd6,
      OP_Y2X  = 3'd7
   } xfer_op_e;
endpackage

// File: rtl/rtm_acc_reg.sv
`timescale 1ns/1ps
module rtm_acc_reg #(
   parameter int BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [BYTE_W-1:0] lo_d_i,
   input  logic [BYTE_W-1:0] hi_d_i,
   output logic [BYTE_W-1:0] lo_q_o,
   output logic [BYTE_W-1:0] hi_q_o
);
   initial begin
      assert (BYTE_W >= 1) else $error("rtm_acc_reg: BYTE_W must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lo_q_o <= '0;
         hi_q_o <= '0;
      end else begin
         if (wr_lo_i) lo_q_o <= lo_d_i;
         if (wr_hi_i) hi_q_o <= hi_d_i;
      end
   end

   // R7
   hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_hi_i |=> $stable(hi_q_o));
endmodule

// File: rtl/rtm_idx_reg.sv
`timescale 1ns/1ps
module rtm_idx_reg #(
   parameter int BYTE_W = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                narrow_i,
   input  logic                wr_i,
   input  logic [2*BYTE_W-1:0] d_i,
   output logic [2*BYTE_W-1:0] q_o
);
   localparam int W = 2 * BYTE_W;

   logic [BYTE_W-1:0] lo_r, hi_r;

   initial begin
      assert (BYTE_W >= 1) else $error("rtm_idx_reg: BYTE_W must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lo_r <= '0;
         hi_r <= '0;
      end else begin
         if (wr_i) lo_r <= d_i[BYTE_W-1:0];
         if (narrow_i)  hi_r <= '0;
         else if (wr_i) hi_r <= d_i[W-1:BYTE_W];
      end
   end

   assign q_o = {(narrow_i ? {BYTE_W{1'b0}} : hi_r), lo_r};

   // R11
   hi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      narrow_i |=> (hi_r == '0));
endmodule

// File: rtl/rtm_xfer_unit.sv
`timescale 1ns/1ps
module rtm_xfer_unit
   import rtm_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int W      = 2 * BYTE_W
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [2:0]   op_i,
   input  logic         acc_narrow_i,
   input  logic         idx_narrow_i,
   input  logic         ld_acc_i,
   input  logic [W-1:0] ld_acc_val_i,
   input  logic         ld_x_i,
   input  logic [W-1:0] ld_x_val_i,
   input  logic         ld_y_i,
   input  logic [W-1:0] ld_y_val_i,
   output logic [W-1:0] acc_o,
   output logic [W-1:0] x_o,
   output logic [W-1:0] y_o
);
   localparam int NUM_IDX = 2;

   initial begin
      assert (W == 2 * BYTE_W) else $error("rtm_xfer_unit: W must equal 2*BYTE_W");
   end

   xfer_op_e          op;
   logic [BYTE_W-1:0] acc_lo, acc_hi;
   logic [BYTE_W-1:0] acc_lo_d, acc_hi_d;
   logic              acc_wr_lo, acc_wr_hi;
   logic [W-1:0]      idx_q   [NUM_IDX];
   logic [W-1:0]      ld_val  [NUM_IDX];
   logic [NUM_IDX-1:0] ld_idx;
   logic [W-1:0]      idx_src;

   assign op        = xfer_op_e'(op_i);
   assign ld_idx    = {ld_y_i, ld_x_i};
   assign ld_val[0] = ld_x_val_i;
   assign ld_val[1] = ld_y_val_i;
   assign idx_src   = (op == OP_X2A) ? idx_q[0] : idx_q[1];

   // accumulator write selection: loads first, then moves
   always_comb begin
      acc_wr_lo = 1'b0;
      acc_wr_hi = 1'b0;
      acc_lo_d  = '0;
      acc_hi_d  = '0;
      if (ld_acc_i) begin
         acc_wr_lo = 1'b1;
         acc_wr_hi = !acc_narrow_i;
         acc_lo_d  = ld_acc_val_i[BYTE_W-1:0];
         acc_hi_d  = ld_acc_val_i[W-1:BYTE_W];
      end else begin
         unique case (op)
            OP_SWAP: begin
               acc_wr_lo = 1'b1;
               acc_wr_hi = 1'b1;
               acc_lo_d  = acc_hi;
               acc_hi_d  = acc_lo;
            end
            OP_X2A, OP_Y2A: begin
               acc_wr_lo = 1'b1;
               acc_wr_hi = !acc_narrow_i;
               acc_lo_d  = idx_src[BYTE_W-1:0];
               acc_hi_d  = idx_src[W-1:BYTE_W];
            end
            default: ;
         endcase
      end
   end

   rtm_acc_reg #(.BYTE_W(BYTE_W)) acc_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_lo_i (acc_wr_lo),
      .wr_hi_i (acc_wr_hi),
      .lo_d_i  (acc_lo_d),
      .hi_d_i  (acc_hi_d),
      .lo_q_o  (acc_lo),
      .hi_q_o  (acc_hi)
   );

   for (genvar k = 0; k < NUM_IDX; k++) begin : gen_idx
      localparam int       PEER     = NUM_IDX - 1 - k;
      localparam xfer_op_e FROM_ACC = (k == 0) ? OP_A2X : OP_A2Y;
      localparam xfer_op_e FROM_PEER = (k == 0) ? OP_Y2X : OP_X2Y;

      logic         wr;
      logic [W-1:0] d;

      always_comb begin
         wr = 1'b1;
         if (ld_idx[k])              d = ld_val[k];
         else if (op == FROM_ACC)    d = {acc_hi, acc_lo};
         else if (op == FROM_PEER)   d = idx_q[PEER];
         else begin
            wr = 1'b0;
            d  = '0;
         end
      end

      rtm_idx_reg #(.BYTE_W(BYTE_W)) reg_i (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .narrow_i (idx_narrow_i),
         .wr_i     (wr),
         .d_i      (d),
         .q_o      (idx_q[k])
      );
   end

   assign acc_o = {acc_hi, acc_lo};
   assign x_o   = idx_q[0];
   assign y_o   = idx_q[1];

   // R4
   swap_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_SWAP && !ld_acc_i) |=> (acc_o == {$past(acc_lo), $past(acc_hi)}));

   // R6
   a2x_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_A2X && idx_narrow_i && !ld_x_i) |=> (x_o == {{BYTE_W{1'b0}}, $past(acc_lo)}));

   // R8
   x2a_zero_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((op == OP_X2A || op == OP_Y2A) && !acc_narrow_i && idx_narrow_i && !ld_acc_i)
      |=> (acc_hi == '0));

   // R7
   x2a_keep_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((op == OP_X2A || op == OP_Y2A) && acc_narrow_i && !ld_acc_i)
      |=> (acc_hi == $past(acc_hi)));
endmodule

// File: tb/rtm_xfer_unit_tb.sv
`timescale 1ns/1ps
module rtm_xfer_unit_tb_top;
   typedef struct packed {
      logic [2:0]  op;
      logic        an;
      logic        xn;
      logic        la;
      logic        lx;
      logic        ly;
      logic [15:0] va;
      logic [15:0] vx;
      logic [15:0] vy;
      logic [15:0] ea;
      logic [15:0] ex;
      logic [15:0] ey;
   } vec_t;

   localparam int NV = 18;
   // each row: op an xn la lx ly  va vx vy  expected acc x y
   localparam vec_t TBL [NV] = '{
      '{3'd0,1'b0,1'b0,1'b1,1'b1,1'b1,16'h1234,16'h5678,16'h9ABC,16'h1234,16'h5678,16'h9ABC}, // R2 wide loads
      '{3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'h3412,16'h5678,16'h9ABC},          // R4 swap wide
      '{3'd1,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'h1234,16'h5678,16'h9ABC},          // R4 swap narrow
      '{3'd2,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'h1234,16'h1234,16'h9ABC},          // R5 A->X
      '{3'd3,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'h1234,16'h1234,16'h1234},          // R5 A->Y
      '{3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,16'h0,16'hCAFE,16'h0,16'h1234,16'hCAFE,16'h1234},       // R2 load X
      '{3'd4,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'h12FE,16'hCAFE,16'h1234},          // R7 X->A narrow acc
      '{3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'hCAFE,16'hCAFE,16'h1234},          // R8 X->A wide
      '{3'd7,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'hCAFE,16'h1234,16'h1234},          // R9 Y->X
      '{3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'hCAFE,16'h0034,16'h0034},          // R10 narrow view
      '{3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'hCAFE,16'h0034,16'h0034},          // R11 cleared high
      '{3'd2,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'hCAFE,16'h00FE,16'h0034},          // R6 A->X narrow
      '{3'd4,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'h00FE,16'h00FE,16'h0034},          // R8 zero B
      '{3'd6,1'b0,1'b1,1'b1,1'b0,1'b0,16'hABCD,16'h0,16'h0,16'hABCD,16'h00FE,16'h00FE},       // R9 X->Y, R2
      '{3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,16'h0,16'h7788,16'h0,16'hABCD,16'h0088,16'h00FE},       // R2 narrow X load
      '{3'd2,1'b0,1'b0,1'b0,1'b1,1'b0,16'h0,16'h1111,16'h0,16'hABCD,16'h1111,16'h00FE},       // R2 load wins
      '{3'd0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h5566,16'h0,16'h0,16'hAB66,16'h1111,16'h00FE},       // R2 narrow acc load
      '{3'd5,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0,16'h0,16'h0,16'hABFE,16'h1111,16'h00FE}           // R7 Y->A narrow acc
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op = 3'd0;
   logic        an = 1'b0, xn = 1'b0, la = 1'b0, lx = 1'b0, ly = 1'b0;
   logic [15:0] va = '0, vx = '0, vy = '0;
   logic [15:0] acc, x, y;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   rtm_xfer_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .op_i(op),
      .acc_narrow_i(an), .idx_narrow_i(xn),
      .ld_acc_i(la), .ld_acc_val_i(va),
      .ld_x_i(lx), .ld_x_val_i(vx),
      .ld_y_i(ly), .ld_y_val_i(vy),
      .acc_o(acc), .x_o(x), .y_o(y)
   );

   task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      op = v.op; an = v.an; xn = v.xn; la = v.la; lx = v.lx; ly = v.ly;
      va = v.va; vx = v.vx; vy = v.vy;
   endtask

   task automatic idle();
      op = 3'd0; la = 1'b0; lx = 1'b0; ly = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #500000;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1", "acc after reset", acc, 16'h0);
      check("R1", "x after reset", x, 16'h0);
      check("R1", "y after reset", y, 16'h0);
      rst_n = 1'b1;

      @(negedge clk);
      apply(TBL[0]);
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         check($sformatf("R%0d-row%0d", 3, i), "acc", acc, TBL[i].ea);
         check($sformatf("R%0d-row%0d", 3, i), "x", x, TBL[i].ex);
         check($sformatf("R%0d-row%0d", 3, i), "y", y, TBL[i].ey);
         if (i + 1 < NV) apply(TBL[i + 1]);
      end
      idle();
      an = 1'b0; xn = 1'b0;
      @(negedge clk);

      // R12: a swap does not show before the edge; R3 opcode 1 is swap
      op = 3'd1;
      #1;
      check("R12", "acc before edge", acc, 16'hABFE);
      @(negedge clk);
      check("R12", "acc after edge", acc, 16'hFEAB);
      idle();

      // R10: mask is immediate, no edge in between
      xn = 1'b1;
      #1;
      check("R10", "x masked same cycle", x, 16'h0011);
      check("R10", "y masked same cycle", y, 16'h00FE);
      xn = 1'b0;
      #1;
      check("R10", "x unmasked before edge", x, 16'h1111);

      // R3: opcode 0 holds everything
      @(negedge clk);
      @(negedge clk);
      check("R3", "acc held on no move", acc, 16'hFEAB);
      check("R3", "x held on no move", x, 16'h1111);

      // R1: reset mid-run clears everything
      rst_n = 1'b0;
      #1;
      check("R1", "acc after async reset", acc, 16'h0);
      check("R1", "x after async reset", x, 16'h0);
      check("R1", "y after async reset", y, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule